// File: doc/BRIEF.md
# Banked memory chip-select decoder

This block sits between an 8-bit CPU's 16-bit address bus and the memories behind it. Each cycle it sorts the address into one of four 16 KiB windows. From that window and a small set of configuration registers it decides which memory answers: a first external memory, a second external memory, or an internal banked ROM. It drives two active-low chip enables, a 7-line bank bus and an internal ROM select with a 2-bit bank index. It raises a flag when the access falls into a window that the current mapping forbids.

Three registers are written through a simple strobe-and-select port. The first is a 5-bit primary bank number. The second is a 7-bit secondary register, whose low five bits are the bank number of the second memory and whose top two bits are general-purpose outputs. The third is a 2-bit mapping control. An input pin says whether the internal ROM exists. A sleep input holds both external enables inactive.

The decode result is held as a state that is reloaded at every clock edge. The states are ST_QUIET (no memory addressed), ST_CHIP1 (first external memory), ST_CHIP2 (second external memory), ST_ROM (internal ROM) and ST_BLOCKED (forbidden access). Reset enters ST_QUIET. At every edge the state moves to the one the current address class names: address below 0x4000 goes to ST_QUIET; 0x4000–0x7FFF goes to ST_CHIP1 or ST_BLOCKED; 0x8000–0xBFFF goes to ST_CHIP2, ST_ROM or ST_BLOCKED; 0xC000–0xFFFF goes to ST_CHIP2 or ST_ROM. Any state may follow any state.

Top module: `bankcs_decoder`

## Requirements
- R1: After reset all three registers are zero and the outputs read ext1_cs_n=1, ext2_cs_n=1, bank_out=0, rom_sel=0, rom_bank=0, access_blocked=0.
- R2: A write with cfg_we=1 loads one register at the clock edge, chosen by cfg_sel: 0 selects the primary bank (cfg_wdata[4:0]), 1 selects the secondary register (cfg_wdata[6:0]), 2 selects mapping control (cfg_wdata[1:0]). A write with cfg_sel=3 changes no register.
- R3: An address below 0x4000 asserts no enable, no ROM select and no blocked flag.
- R4: For 0x4000–0x7FFF with mapping bit 0 clear, ext1_cs_n is 0 and bank_out[4:0] equals the primary bank.
- R5: For 0x8000–0xBFFF with mapping bits {1,0}=00, ext2_cs_n is 0 and bank_out[4:0] equals secondary bits 4:0. The ROM pin has no effect here.
- R6: For 0x8000–0xBFFF with mapping {1,0}=10 and rom_on=0, ext2_cs_n is 0 and bank_out[4:0] equals the primary bank.
- R7: For 0x8000–0xBFFF with mapping bit 1 set and rom_on=1 (either value of bit 0), rom_sel is 1, rom_bank equals primary bank bits 1:0, and both external enables stay 1.
- R8: For 0xC000–0xFFFF the bank is always 0x1F. With rom_on=1, rom_sel is 1 and rom_bank is 3. With rom_on=0, ext2_cs_n is 0 and bank_out[4:0] is 0x1F.
- R9: access_blocked is 1 with no enable and no ROM select in two cases: for 0x4000–0x7FFF when mapping bit 0 is set, and for 0x8000–0xBFFF when mapping bit 0 is set unless bit 1 and rom_on are both 1.
- R10: Whenever the state is not ST_CHIP2, bank_out[4:0] shows the primary bank register. rom_bank is 0 whenever rom_sel is 0.
- R11: bank_out[6:5] always shows secondary register bits 6:5.
- R12: While sleep_req is 1, both external enables are 1 in that same cycle. The bank lines, ROM select and blocked flag are unaffected.
- R13: Decode results appear one clock edge after the address is applied, for back-to-back addresses. A register write is seen by addresses applied after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 primary bank, 1 secondary, 2 mapping, 3 none) |
| cfg_wdata | input | 7 | Register write data |
| rom_on | input | 1 | Internal ROM present |
| sleep_req | input | 1 | Holds both external enables inactive |
| cpu_addr | input | 16 | CPU address |
| ext1_cs_n | output | 1 | Enable of external memory 1, active low |
| ext2_cs_n | output | 1 | Enable of external memory 2, active low |
| bank_out | output | 7 | Bank lines; 6:5 general purpose, 4:0 bank number |
| rom_sel | output | 1 | Internal ROM selected |
| rom_bank | output | 2 | Internal ROM bank index (bank 0x1C + index) |
| access_blocked | output | 1 | Access falls in a forbidden window |

## Verification
Every decode result is due one clock edge after its address is driven. A register write is due one edge after its strobe, and the bench never overlaps it with a pending check. The sleep gating is combinational and holds during the cycle in which its result is read. The driver applies inputs on the falling edge and queues the expected item, tagged with the cycle count of the next rising edge. The monitor compares a quarter period after that rising edge, while the driver's inputs still hold, so neither the registered nor the combinational results race with the stimulus.

// File: rtl/bankcs_pkg.sv
package bankcs_pkg;

    typedef enum logic [2:0] {
        ST_QUIET   = 3'd0,
        ST_CHIP1   = 3'd1,
        ST_CHIP2   = 3'd2,
        ST_ROM     = 3'd3,
        ST_BLOCKED = 3'd4
    } bankcs_state_e;

    localparam logic [1:0] SEL_PRIMARY   = 2'd0;
    localparam logic [1:0] SEL_SECONDARY = 2'd1;
    localparam logic [1:0] SEL_MAPPING   = 2'd2;

    localparam logic [1:0] WIN_LOW  = 2'b00;
    localparam logic [1:0] WIN_EXT1 = 2'b01;
    localparam logic [1:0] WIN_MID  = 2'b10;
    localparam logic [1:0] WIN_TOP  = 2'b11;

endpackage

// File: rtl/bankcs_cfg_regs.sv
module bankcs_cfg_regs
    import bankcs_pkg::*;
#(
    parameter int BANK_W = 5,
    parameter int GPO_W  = 2,
    localparam int SEC_W = BANK_W + GPO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [SEC_W-1:0]  wdata,
    output logic [BANK_W-1:0] primary_q,
    output logic [SEC_W-1:0]  secondary_q,
    output logic [1:0]        mapping_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primary_q   <= '0;
            secondary_q <= '0;
            mapping_q   <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_PRIMARY:   primary_q   <= wdata[BANK_W-1:0];
                SEL_SECONDARY: secondary_q <= wdata;
                SEL_MAPPING:   mapping_q   <= wdata[1:0];
                default: ;
            endcase
        end
    end

    // R2: the spare select code leaves every register untouched
    assert_spare_sel_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == 2'b11) |=> ($stable(primary_q) && $stable(secondary_q) && $stable(mapping_q)));

endmodule

// File: rtl/bankcs_classify.sv
module bankcs_classify
    import bankcs_pkg::*;
#(
    parameter int BANK_W = 5,
    parameter int ROM_W  = 2
) (
    input  logic [1:0]        win,
    input  logic [1:0]        mapping,
    input  logic              rom_on,
    input  logic [BANK_W-1:0] primary,
    input  logic [BANK_W-1:0] sec_bank,
    output bankcs_state_e     nxt_state,
    output logic [BANK_W-1:0] nxt_chip2_bank,
    output logic [ROM_W-1:0]  nxt_rom_idx
);

    always_comb begin
        nxt_state      = ST_QUIET;
        nxt_chip2_bank = primary;
        nxt_rom_idx    = '0;
        unique case (win)
            WIN_LOW: nxt_state = ST_QUIET;
            WIN_EXT1: nxt_state = mapping[0] ? ST_BLOCKED : ST_CHIP1;
            WIN_MID: begin
                if (mapping[1] && rom_on) begin
                    nxt_state   = ST_ROM;
                    nxt_rom_idx = primary[ROM_W-1:0];
                end else if (mapping == 2'b00) begin
                    nxt_state      = ST_CHIP2;
                    nxt_chip2_bank = sec_bank;
                end else if (mapping == 2'b10) begin
                    nxt_state      = ST_CHIP2;
                    nxt_chip2_bank = primary;
                end else begin
                    nxt_state = ST_BLOCKED;
                end
            end
            WIN_TOP: begin
                if (rom_on) begin
                    nxt_state   = ST_ROM;
                    nxt_rom_idx = '1;
                end else begin
                    nxt_state      = ST_CHIP2;
                    nxt_chip2_bank = '1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bankcs_drive.sv
module bankcs_drive
    import bankcs_pkg::*;
#(
    parameter int BANK_W = 5,
    parameter int GPO_W  = 2,
    parameter int ROM_W  = 2
) (
    input  bankcs_state_e            state,
    input  logic [BANK_W-1:0]        chip2_bank,
    input  logic [ROM_W-1:0]         rom_idx,
    input  logic [BANK_W-1:0]        primary,
    input  logic [GPO_W-1:0]         gpo,
    input  logic                     sleep_req,
    output logic                     ext1_cs_n,
    output logic                     ext2_cs_n,
    output logic [BANK_W+GPO_W-1:0]  bank_out,
    output logic                     rom_sel,
    output logic [ROM_W-1:0]         rom_bank,
    output logic                     access_blocked
);

    logic [BANK_W-1:0] bank_lo;

    always_comb begin
        ext1_cs_n      = 1'b1;
        ext2_cs_n      = 1'b1;
        bank_lo        = primary;
        rom_sel        = 1'b0;
        rom_bank       = '0;
        access_blocked = 1'b0;
        unique case (state)
            ST_QUIET: ;
            ST_CHIP1: ext1_cs_n = sleep_req;
            ST_CHIP2: begin
                ext2_cs_n = sleep_req;
                bank_lo   = chip2_bank;
            end
            ST_ROM: begin
                rom_sel  = 1'b1;
                rom_bank = rom_idx;
            end
            ST_BLOCKED: access_blocked = 1'b1;
            default: ;
        endcase
        bank_out = {gpo, bank_lo};
    end

endmodule

// File: rtl/bankcs_decoder.sv
module bankcs_decoder
    import bankcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 5,
    parameter int GPO_W  = 2,
    parameter int ROM_W  = 2,
    localparam int SEC_W = BANK_W + GPO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [SEC_W-1:0]  cfg_wdata,
    input  logic              rom_on,
    input  logic              sleep_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              ext1_cs_n,
    output logic              ext2_cs_n,
    output logic [SEC_W-1:0]  bank_out,
    output logic              rom_sel,
    output logic [ROM_W-1:0]  rom_bank,
    output logic              access_blocked
);

    localparam logic [ADDR_W-1:0] LOW_LIMIT = ADDR_W'(1) << (ADDR_W - 2);

    logic [BANK_W-1:0] primary_q;
    logic [SEC_W-1:0]  secondary_q;
    logic [1:0]        mapping_q;

    bankcs_state_e     state_q, state_d;
    logic [BANK_W-1:0] chip2_bank_q, chip2_bank_d;
    logic [ROM_W-1:0]  rom_idx_q, rom_idx_d;

    bankcs_cfg_regs #(.BANK_W(BANK_W), .GPO_W(GPO_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .sel         (cfg_sel),
        .wdata       (cfg_wdata),
        .primary_q   (primary_q),
        .secondary_q (secondary_q),
        .mapping_q   (mapping_q)
    );

    bankcs_classify #(.BANK_W(BANK_W), .ROM_W(ROM_W)) u_classify (
        .win            (cpu_addr[ADDR_W-1 -: 2]),
        .mapping        (mapping_q),
        .rom_on         (rom_on),
        .primary        (primary_q),
        .sec_bank       (secondary_q[BANK_W-1:0]),
        .nxt_state      (state_d),
        .nxt_chip2_bank (chip2_bank_d),
        .nxt_rom_idx    (rom_idx_d)
    );

    // State register: reloaded with the class of the current address each edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_QUIET;
            chip2_bank_q <= '0;
            rom_idx_q    <= '0;
        end else begin
            state_q      <= state_d;
            chip2_bank_q <= chip2_bank_d;
            rom_idx_q    <= rom_idx_d;
        end
    end

    bankcs_drive #(.BANK_W(BANK_W), .GPO_W(GPO_W), .ROM_W(ROM_W)) u_drive (
        .state          (state_q),
        .chip2_bank     (chip2_bank_q),
        .rom_idx        (rom_idx_q),
        .primary        (primary_q),
        .gpo            (secondary_q[SEC_W-1:BANK_W]),
        .sleep_req      (sleep_req),
        .ext1_cs_n      (ext1_cs_n),
        .ext2_cs_n      (ext2_cs_n),
        .bank_out       (bank_out),
        .rom_sel        (rom_sel),
        .rom_bank       (rom_bank),
        .access_blocked (access_blocked)
    );

    assert_low_window_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < LOW_LIMIT) |=> (ext1_cs_n && ext2_cs_n && !rom_sel && !access_blocked));

    assert_chip1_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ext1_cs_n |-> (bank_out[BANK_W-1:0] == primary_q));

    assert_rom_keeps_chips_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (ext1_cs_n && ext2_cs_n));

    assert_top_window_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[ADDR_W-1 -: 2] == 2'b11 && !rom_on) |=> (bank_out[BANK_W-1:0] == '1));

    assert_blocked_is_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        access_blocked |-> (ext1_cs_n && ext2_cs_n && !rom_sel));

    assert_sleep_no_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext1_cs_n || !ext2_cs_n) |-> !sleep_req);

endmodule

// File: tb/bankcs_decoder_test.sv
module bankcs_decoder_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [6:0]  cfg_wdata = '0;
    logic        rom_on = 1'b0;
    logic        sleep_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        ext1_cs_n, ext2_cs_n, rom_sel, access_blocked;
    logic [6:0]  bank_out;
    logic [1:0]  rom_bank;

    bankcs_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rom_on(rom_on), .sleep_req(sleep_req),
        .cpu_addr(cpu_addr), .ext1_cs_n(ext1_cs_n), .ext2_cs_n(ext2_cs_n),
        .bank_out(bank_out), .rom_sel(rom_sel), .rom_bank(rom_bank),
        .access_blocked(access_blocked)
    );

    always #(PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    logic [4:0] m_primary = '0;
    logic [6:0] m_secondary = '0;
    logic [1:0] m_map = '0;

    typedef struct {
        logic [12:0] vec;
        int          due;
        string       tag;
    } item_t;

    item_t sb[$];

    task automatic put_cfg(input logic [1:0] sel, input logic [6:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        case (sel)
            2'd0: m_primary = d[4:0];
            2'd1: m_secondary = d;
            2'd2: m_map = d[1:0];
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drives one address and queues the outcome the requirements predict
    task automatic access(input logic [15:0] a, input logic rom, input logic slp, input string tag);
        item_t e;
        logic c1, c2, rs, bk;
        logic [4:0] lo;
        logic [1:0] rb;
        @(negedge clk);
        cpu_addr = a; rom_on = rom; sleep_req = slp;
        c1 = 1'b1; c2 = 1'b1; rs = 1'b0; bk = 1'b0; rb = 2'd0; lo = m_primary;
        case (a[15:14])
            2'b01: if (m_map[0]) bk = 1'b1; else c1 = 1'b0;
            2'b10: begin
                if (m_map[1] && rom) begin rs = 1'b1; rb = m_primary[1:0]; end
                else if (m_map == 2'b00) begin c2 = 1'b0; lo = m_secondary[4:0]; end
                else if (m_map == 2'b10) c2 = 1'b0;
                else bk = 1'b1;
            end
            2'b11: begin
                if (rom) begin rs = 1'b1; rb = 2'd3; end
                else begin c2 = 1'b0; lo = 5'h1F; end
            end
            default: ;
        endcase
        if (slp) begin c1 = 1'b1; c2 = 1'b1; end
        e.vec = {c1, c2, m_secondary[6:5], lo, rs, rb, bk};
        e.due = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares a quarter period after the edge that produces each result
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (sb.size() > 0 && sb[0].due == cyc) begin
                item_t e;
                logic [12:0] got;
                e = sb.pop_front();
                got = {ext1_cs_n, ext2_cs_n, bank_out, rom_sel, rom_bank, access_blocked};
                checks++;
                if (got !== e.vec) begin
                    errors++;
                    $display("FAIL %s actual=%b expected=%b (ce1 ce2 bank[7] rom rombank[2] blk)",
                             e.tag, got, e.vec);
                end
            end
        end
    end

    initial begin
        #(PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL R13 watchdog expired pending=%0d expected=0", sb.size());
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [12:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        got = {ext1_cs_n, ext2_cs_n, bank_out, rom_sel, rom_bank, access_blocked};
        checks++;
        if (got !== 13'b1_1_0000000_0_00_0) begin
            errors++;
            $display("FAIL R1 reset actual=%b expected=%b", got, 13'b1_1_0000000_0_00_0);
        end

        access(16'h0123, 1'b0, 1'b0, "R3 low window");
        access(16'h3FFF, 1'b1, 1'b0, "R3 low edge");
        access(16'h4000, 1'b0, 1'b0, "R4 chip1 bank0");
        put_cfg(2'd0, 7'h0A);
        access(16'h5555, 1'b0, 1'b0, "R4 chip1 bank 0A");
        access(16'h7FFF, 1'b1, 1'b0, "R4 chip1 top edge");

        put_cfg(2'd1, 7'h7D);
        access(16'h8000, 1'b0, 1'b0, "R5 chip2 secondary bank");
        access(16'hBFFF, 1'b1, 1'b0, "R5 rom pin no effect");
        access(16'h1000, 1'b0, 1'b0, "R10 R11 primary and gpo");

        put_cfg(2'd2, 7'h02);
        access(16'h9000, 1'b0, 1'b0, "R6 chip2 primary bank");
        access(16'hBFFF, 1'b1, 1'b0, "R7 rom bank idx 2");
        put_cfg(2'd0, 7'h1D);
        access(16'hA000, 1'b1, 1'b0, "R7 rom bank idx 1");

        put_cfg(2'd2, 7'h03);
        access(16'h8000, 1'b1, 1'b0, "R7 map 11 rom");
        access(16'h4000, 1'b1, 1'b0, "R9 chip1 window blocked");
        access(16'h8000, 1'b0, 1'b0, "R9 map 11 no rom blocked");
        put_cfg(2'd2, 7'h01);
        access(16'h8000, 1'b1, 1'b0, "R9 map 01 blocked");
        access(16'hC000, 1'b0, 1'b0, "R8 top window map 01");

        put_cfg(2'd2, 7'h00);
        access(16'hC000, 1'b0, 1'b0, "R8 top chip2 1F");
        access(16'hFFFF, 1'b1, 1'b0, "R8 top rom idx 3");
        access(16'hE000, 1'b0, 1'b0, "R10 after rom bank idx cleared");

        access(16'h4000, 1'b0, 1'b1, "R12 sleep chip1");
        access(16'h8000, 1'b0, 1'b1, "R12 sleep chip2 bank kept");
        access(16'h8000, 1'b0, 1'b0, "R12 wake chip2");

        put_cfg(2'd3, 7'h7F);
        access(16'h1000, 1'b0, 1'b0, "R2 spare select banks unchanged");
        access(16'h4000, 1'b0, 1'b0, "R2 spare select mapping unchanged");

        access(16'h4000, 1'b0, 1'b0, "R13 burst chip1");
        access(16'h8000, 1'b0, 1'b0, "R13 burst chip2");
        access(16'hC000, 1'b1, 1'b0, "R13 burst rom");
        access(16'h0000, 1'b0, 1'b0, "R13 burst quiet");
        access(16'hC000, 1'b0, 1'b0, "R13 burst top chip2");

        wait (sb.size() == 0);
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule